// File: doc/BRIEF.md
# Periodic IN Token Queue

This block sits inside a full-speed host controller, between the host channels and the frame scheduler. A channel that wants periodic IN data writes its enable; each such write posts one request carrying the channel number, the parity of the frame it wants (odd or even) and a packet count for high-bandwidth endpoints. The queue holds up to four requests. At every start-of-frame it latches bit 0 of the frame number and makes the waiting requests eligible. It then releases the head request as one or more IN token strobes, one per cycle, tagged with the channel number.

Requests leave strictly in arrival order. A head whose parity does not match the current frame blocks everything behind it until a frame of the right parity begins. A head that is part way through its burst when the next start-of-frame arrives is dropped, because its frame has ended. A write that finds the queue full is refused and raises a sticky overflow flag. A free-slot count shows the channels how much room is left.

Top module: `perq_sched`

## Requirements
- R1: After reset no token is issued, the free count equals the depth (4) and the overflow flag is 0.
- R2: A channel-enable write while the free count is non-zero stores the request, and the free count is one lower on the next cycle unless a request retires in the same cycle.
- R3: A write while the free count is 0 is refused. The stored requests and their order stay the same, and the overflow flag reads 1 from the next cycle.
- R4: Once set, the overflow flag stays at 1 until reset.
- R5: The head request issues tokens only when its odd flag (1 = odd, 0 = even) equals bit 0 of the frame number captured on the most recent start-of-frame pulse.
- R6: A request becomes eligible only at the first start-of-frame after the cycle in which it was written. No token is issued in a cycle in which the start-of-frame pulse is high.
- R7: A request with multi-count N issues N tokens for its channel on consecutive cycles. An N of 0 is treated as 1.
- R8: Tokens leave in write order. A head that does not match the frame parity holds back every later request until a frame of its parity begins.
- R9: The free count always equals the number of empty slots. It rises one cycle after the final token of a request.
- R10: A start-of-frame pulse that arrives after a request has issued some, but not all, of its tokens removes that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Channel-enable write strobe, posts one request |
| req_ch | input | CH_W (4) | Channel number of the request |
| req_odd | input | 1 | 1 = wants odd frame, 0 = even frame |
| req_mcnt | input | MC_W (2) | Tokens per frame, 0 treated as 1 |
| sof | input | 1 | Start-of-frame pulse |
| frame_num | input | FN_W (11) | Current frame number, bit 0 sampled on sof |
| tok_vld | output | 1 | IN token issue strobe |
| tok_ch | output | CH_W (4) | Channel of the issued token |
| free_cnt | output | $clog2(DEPTH+1) (3) | Number of empty slots |
| ovf | output | 1 | Sticky refused-write flag |

## Verification
A wrong ring pointer or slot valid bit shows up on the first token after the next start-of-frame, as a token with the wrong channel or a token out of order. A free count that has drifted shows one cycle after the next write or pop. A bad eligibility bit shows as a token in the frame where the request was written, or as a missing token in the following frame. A burst counter that is off shows within a few cycles, as a token train of the wrong length or as a head that never retires and blocks the queue from then on.

// File: rtl/perq_pkg.sv
package perq_pkg;

  // Wrap-around increment for a ring of 'depth' slots.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Tokens a request releases in its frame: a zero count still gives one.
  function automatic int unsigned burst_len(input int unsigned mc);
    return (mc == 0) ? 1 : mc;
  endfunction

  // Empty slots given an occupancy.
  function automatic int unsigned slots_free(input int unsigned used, input int unsigned depth);
    return depth - used;
  endfunction

endpackage

// File: rtl/perq_frame.sv
module perq_frame #(
  parameter int unsigned FN_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof,
  input  logic [FN_W-1:0] frame_num,
  output logic            par_odd
);
  logic par_q;
  logic unused_frame_hi;

  assign unused_frame_hi = ^frame_num[FN_W-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n)   par_q <= 1'b0;
    else if (sof) par_q <= frame_num[0];
  end

  assign par_odd = par_q;
endmodule

// File: rtl/perq_store.sv
module perq_store
  import perq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CH_W  = 4,
  parameter int unsigned MC_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       arm_all,
  input  logic [CH_W-1:0]            wr_ch,
  input  logic                       wr_odd,
  input  logic [MC_W-1:0]            wr_mcnt,
  output logic                       hd_valid,
  output logic                       hd_armed,
  output logic [CH_W-1:0]            hd_ch,
  output logic                       hd_odd,
  output logic [MC_W-1:0]            hd_mcnt,
  output logic [$clog2(DEPTH+1)-1:0] used
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [CH_W-1:0] ch_q  [DEPTH];
  logic [MC_W-1:0] mc_q  [DEPTH];
  logic            odd_q [DEPTH];
  logic            vld_q [DEPTH];
  logic            arm_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_wr, hit_rd;
    assign hit_wr = push && (wr_q == PTR_W'(g));
    assign hit_rd = pop  && (rd_q == PTR_W'(g));

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        ch_q[g]  <= wr_ch;
        odd_q[g] <= wr_odd;
        mc_q[g]  <= wr_mcnt;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        arm_q[g] <= 1'b0;
      end else begin
        if (hit_wr)      vld_q[g] <= 1'b1;
        else if (hit_rd) vld_q[g] <= 1'b0;
        if (hit_wr)                    arm_q[g] <= 1'b0;
        else if (arm_all && vld_q[g])  arm_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= PTR_W'(ring_next(32'(wr_q), DEPTH));
      if (pop)  rd_q <= PTR_W'(ring_next(32'(rd_q), DEPTH));
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign hd_valid = vld_q[rd_q];
  assign hd_armed = arm_q[rd_q];
  assign hd_ch    = ch_q[rd_q];
  assign hd_odd   = odd_q[rd_q];
  assign hd_mcnt  = mc_q[rd_q];
  assign used     = cnt_q;
endmodule

// File: rtl/perq_issue.sv
module perq_issue
  import perq_pkg::*;
#(
  parameter int unsigned MC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hd_valid,
  input  logic            hd_armed,
  input  logic            hd_odd,
  input  logic [MC_W-1:0] hd_mcnt,
  input  logic            par_odd,
  input  logic            sof,
  output logic            issue,
  output logic            last,
  output logic            retire
);
  logic [MC_W-1:0] sent_q;
  logic [MC_W-1:0] target;
  logic [MC_W-1:0] sent_nx;

  assign target  = MC_W'(burst_len(32'(hd_mcnt)));
  assign sent_nx = sent_q + MC_W'(1);
  assign issue   = hd_valid && hd_armed && (hd_odd == par_odd) && !sof;
  assign last    = issue && (sent_nx == target);
  assign retire  = sof && (sent_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               sent_q <= '0;
    else if (last || retire)  sent_q <= '0;
    else if (issue)           sent_q <= sent_nx;
  end
endmodule

// File: rtl/perq_sched.sv
module perq_sched
  import perq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CH_W  = 4,
  parameter int unsigned MC_W  = 2,
  parameter int unsigned FN_W  = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_wr,
  input  logic [CH_W-1:0]            req_ch,
  input  logic                       req_odd,
  input  logic [MC_W-1:0]            req_mcnt,
  input  logic                       sof,
  input  logic [FN_W-1:0]            frame_num,
  output logic                       tok_vld,
  output logic [CH_W-1:0]            tok_ch,
  output logic [$clog2(DEPTH+1)-1:0] free_cnt,
  output logic                       ovf
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic            par_odd;
  logic            hd_valid, hd_armed, hd_odd;
  logic [CH_W-1:0] hd_ch;
  logic [MC_W-1:0] hd_mcnt;
  logic [CNT_W-1:0] used;
  logic            full;

  // Named internal events
  logic push_ev, refuse_ev, issue_ev, last_ev, retire_ev, pop_ev;
  logic ovf_q;

  assign full      = (used == CNT_W'(DEPTH));
  assign push_ev   = req_wr && !full;
  assign refuse_ev = req_wr && full;
  assign pop_ev    = last_ev || retire_ev;

  perq_frame #(.FN_W(FN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sof(sof), .frame_num(frame_num), .par_odd(par_odd)
  );

  perq_store #(.DEPTH(DEPTH), .CH_W(CH_W), .MC_W(MC_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .pop(pop_ev), .arm_all(sof),
    .wr_ch(req_ch), .wr_odd(req_odd), .wr_mcnt(req_mcnt),
    .hd_valid(hd_valid), .hd_armed(hd_armed), .hd_ch(hd_ch), .hd_odd(hd_odd),
    .hd_mcnt(hd_mcnt), .used(used)
  );

  perq_issue #(.MC_W(MC_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_armed(hd_armed),
    .hd_odd(hd_odd), .hd_mcnt(hd_mcnt), .par_odd(par_odd), .sof(sof),
    .issue(issue_ev), .last(last_ev), .retire(retire_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         ovf_q <= 1'b0;
    else if (refuse_ev) ovf_q <= 1'b1;
  end

  assign tok_vld  = issue_ev;
  assign tok_ch   = hd_ch;
  assign free_cnt = CNT_W'(slots_free(32'(used), DEPTH));
  assign ovf      = ovf_q;
endmodule

// File: rtl/perq_sched_chk.sv
module perq_sched_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CH_W  = 4,
  parameter int unsigned FN_W  = 11
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_wr,
  input logic                       sof,
  input logic [FN_W-1:0]            frame_num,
  input logic                       tok_vld,
  input logic [CH_W-1:0]            tok_ch,
  input logic [$clog2(DEPTH+1)-1:0] free_cnt,
  input logic                       ovf,
  input logic                       pop_ev,
  input logic                       hd_odd
);
  logic par_chk;
  logic sof_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_chk  <= 1'b0;
      sof_seen <= 1'b0;
    end else if (sof) begin
      par_chk  <= frame_num[0];
      sof_seen <= 1'b1;
    end
  end

  a_r2_push_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && (free_cnt != 0) && !pop_ev |=> free_cnt == $past(free_cnt) - 1);

  a_r3_refuse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && (free_cnt == 0) |=> ovf);

  a_r3_refuse_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && (free_cnt == 0) && !pop_ev |=> free_cnt == 0);

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  a_r5_parity_match: assert property (@(posedge clk) disable iff (!rst_n)
    tok_vld |-> hd_odd == par_chk);

  a_r6_token_after_sof: assert property (@(posedge clk) disable iff (!rst_n)
    tok_vld |-> sof_seen);

  a_r7_burst_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    tok_vld && !pop_ev |=> sof || (tok_vld && $stable(tok_ch)));

  a_r9_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= DEPTH);

  a_r10_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tok_vld) && !$past(pop_ev) && sof && !req_wr |=> free_cnt == $past(free_cnt) + 1);
endmodule

bind perq_sched perq_sched_chk #(.DEPTH(DEPTH), .CH_W(CH_W), .FN_W(FN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .sof(sof), .frame_num(frame_num),
  .tok_vld(tok_vld), .tok_ch(tok_ch), .free_cnt(free_cnt), .ovf(ovf),
  .pop_ev(pop_ev), .hd_odd(hd_odd)
);

// File: tb/sim_perq_sched.sv
module sim_perq_sched;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int CH_W  = 4;
  localparam int MC_W  = 2;
  localparam int FN_W  = 11;
  localparam int NROW  = 24;

  typedef struct packed {
    logic            wr;
    logic [3:0]      ch;
    logic            odd;
    logic [1:0]      mc;
    logic            sof;
    logic [10:0]     fn;
    logic            etok;
    logic [3:0]      ech;
    logic [2:0]      efree;
  } vec_t;

  function automatic vec_t v(input int wr, ch, odd, mc, sf, fn, etok, ech, efree);
    vec_t r;
    r.wr = wr[0]; r.ch = ch[3:0]; r.odd = odd[0]; r.mc = mc[1:0];
    r.sof = sf[0]; r.fn = fn[10:0]; r.etok = etok[0]; r.ech = ech[3:0];
    r.efree = efree[2:0];
    return r;
  endfunction

  // Sequence exercising R2, R5, R6, R7, R8, R9, R10
  localparam vec_t TBL [NROW] = '{
    v(0,0,0,0, 0,0, 0,0,4),
    v(1,3,1,0, 0,0, 0,0,4),   // post ch3 odd, count 0
    v(1,5,0,2, 0,0, 0,0,3),   // post ch5 even, count 2
    v(0,0,0,0, 0,0, 0,0,2),   // not yet eligible (R6)
    v(0,0,0,0, 1,2, 0,0,2),   // even frame starts
    v(0,0,0,0, 0,0, 0,0,2),   // odd head blocks even ch5 (R8)
    v(0,0,0,0, 0,0, 0,0,2),
    v(0,0,0,0, 1,3, 0,0,2),   // odd frame starts
    v(0,0,0,0, 0,0, 1,3,2),   // one token for count 0 (R7)
    v(0,0,0,0, 0,0, 0,0,3),   // ch5 wrong parity (R5)
    v(0,0,0,0, 1,4, 0,0,3),
    v(0,0,0,0, 0,0, 1,5,3),   // burst of two (R7)
    v(0,0,0,0, 0,0, 1,5,3),
    v(0,0,0,0, 0,0, 0,0,4),   // popped (R9)
    v(1,7,1,3, 0,0, 0,0,4),
    v(0,0,0,0, 1,5, 0,0,3),
    v(0,0,0,0, 0,0, 1,7,3),
    v(0,0,0,0, 1,6, 0,0,3),   // sof mid-burst (R10)
    v(1,2,0,1, 0,0, 0,0,4),   // pushed in an even frame
    v(0,0,0,0, 0,0, 0,0,3),   // parity matches but not armed (R6)
    v(0,0,0,0, 0,0, 0,0,3),
    v(0,0,0,0, 1,8, 0,0,3),
    v(0,0,0,0, 0,0, 1,2,3),
    v(0,0,0,0, 0,0, 0,0,4)
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_wr = 1'b0;
  logic [CH_W-1:0] req_ch = '0;
  logic req_odd = 1'b0;
  logic [MC_W-1:0] req_mcnt = '0;
  logic sof = 1'b0;
  logic [FN_W-1:0] frame_num = '0;
  logic tok_vld;
  logic [CH_W-1:0] tok_ch;
  logic [2:0] free_cnt;
  logic ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  perq_sched #(.DEPTH(DEPTH), .CH_W(CH_W), .MC_W(MC_W), .FN_W(FN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_ch(req_ch), .req_odd(req_odd),
    .req_mcnt(req_mcnt), .sof(sof), .frame_num(frame_num), .tok_vld(tok_vld),
    .tok_ch(tok_ch), .free_cnt(free_cnt), .ovf(ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, then let them settle before sampling.
  task automatic drive(input int wr, ch, odd, mc, sf, fn);
    @(negedge clk);
    req_wr = wr[0]; req_ch = ch[CH_W-1:0]; req_odd = odd[0];
    req_mcnt = mc[MC_W-1:0]; sof = sf[0]; frame_num = fn[FN_W-1:0];
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_wr = 1'b0; sof = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset tok_vld", int'(tok_vld), 0);
    chk("R1 reset free_cnt", int'(free_cnt), DEPTH);
    chk("R1 reset ovf", int'(ovf), 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();

    for (int i = 0; i < NROW; i++) begin
      int act;
      int exp;
      drive(TBL[i].wr, TBL[i].ch, TBL[i].odd, TBL[i].mc, TBL[i].sof, TBL[i].fn);
      act = {24'd0, tok_vld, (tok_vld ? tok_ch : 4'd0), free_cnt};
      exp = {24'd0, TBL[i].etok, (TBL[i].etok ? TBL[i].ech : 4'd0), TBL[i].efree};
      checks++;
      if (act != exp) begin
        errors++;
        $display("FAIL row %0d (R2/R5/R6/R7/R8/R9/R10): actual tok=%0d ch=%0d free=%0d expected tok=%0d ch=%0d free=%0d",
                 i, tok_vld, tok_ch, free_cnt, TBL[i].etok, TBL[i].ech, TBL[i].efree);
      end
    end

    // Fill the queue, then overflow it (R2, R3, R4)
    for (int k = 1; k <= DEPTH; k++) drive(1, k, 1, 1, 0, 0);
    drive(1, 9, 0, 3, 0, 0);
    chk("R2 queue full after four writes", int'(free_cnt), 0);
    chk("R3 flag clear before refusal", int'(ovf), 0);
    idle();
    chk("R3 refused write sets flag", int'(ovf), 1);
    chk("R3 refused write keeps full", int'(free_cnt), 0);
    drive(0, 0, 0, 0, 1, 9);
    chk("R6 no token on sof cycle", int'(tok_vld), 0);
    for (int k = 1; k <= DEPTH; k++) begin
      idle();
      chk("R8 token valid in order", int'(tok_vld), 1);
      chk("R3/R8 channel order unchanged", int'(tok_ch), k);
    end
    idle();
    chk("R3 refused request never issued", int'(tok_vld), 0);
    chk("R9 queue empty again", int'(free_cnt), DEPTH);
    chk("R4 flag remains set", int'(ovf), 1);

    do_reset();

    // Full burst of three (R7)
    drive(1, 6, 0, 3, 0, 0);
    drive(0, 0, 0, 0, 1, 10);
    for (int k = 0; k < 3; k++) begin
      idle();
      chk("R7 burst token", int'(tok_vld), 1);
      chk("R7 burst channel", int'(tok_ch), 6);
    end
    idle();
    chk("R7 burst stops at count", int'(tok_vld), 0);
    chk("R9 free after burst", int'(free_cnt), DEPTH);

    // Odd head in an even frame yields nothing (R5)
    drive(1, 11, 1, 1, 0, 0);
    drive(0, 0, 0, 0, 1, 12);
    idle();
    chk("R5 parity mismatch holds", int'(tok_vld), 0);
    drive(0, 0, 0, 0, 1, 13);
    idle();
    chk("R5 issue in odd frame", int'(tok_vld), 1);
    chk("R5 issued channel", int'(tok_ch), 11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule